// File: doc/BRIEF.md
# Mixed-Length Instruction Fetch Aligner

This block sits between a word-wide instruction memory and the decode stage. Instructions are 16 or 32 bits long, freely mixed, and start on any halfword boundary. The block asks memory for aligned 32-bit words and returns whole instructions, one at a time, each with its own byte PC and a length flag. A 32-bit instruction may straddle two fetch words. The block keeps one spare halfword between words so that such an instruction can be joined with the next word.

The length of an instruction is known from a single bit, the top bit of its first halfword. A taken branch or jump enters as a redirect carrying a halfword-aligned target. The redirect flushes the spare halfword and any fetch still in flight. If the target is the upper half of a word, the lower half of the first fetched word is thrown away.

Memory requests and responses and the instruction output are valid/ready streams. A request is accepted when `mem_req_valid` and `mem_req_ready` are both high. Responses come back in order, and the memory keeps a response and its data steady until `mem_rsp_ready` is high. An instruction moves to decode when `ins_valid` and `ins_ready` are both high. While `ins_ready` is low, the presented instruction waits unchanged. The redirect is a plain single-cycle strobe and cannot be refused.

Top module: `fetch_aligner`

## Requirements
- R1: A first halfword with bit 15 set is a 16-bit instruction, presented as `ins_data = {16'h0, halfword}` with `ins_is32 = 0`. A first halfword with bit 15 clear starts a 32-bit instruction, presented as `ins_data = {first, second}` with `ins_is32 = 1`, so `ins_data[31]` is 0.
- R2: Bits 15:0 of a fetch word hold the halfword at the lower address. A 32-bit instruction that starts in the upper half of a word is presented only after the next word arrives, and it is built from both words.
- R3: With no redirect in between, the PC of each instruction is the previous instruction's PC plus 2 after a 16-bit instruction, or plus 4 after a 32-bit one. The PC wraps modulo 2^PC_W.
- R4: During reset and in the first cycle after it, `ins_valid` is low and a request is offered for the word that contains `RESET_PC`. The first instruction presented has PC `RESET_PC`.
- R5: Request addresses have bits 1:0 equal to zero. Without a redirect, they follow each other in steps of 4. At most one request is outstanding: no new request is offered in the cycle after one is accepted.
- R6: In the cycle after a redirect, `ins_valid` is low. The next instruction presented has PC equal to the target with bit 0 cleared. The next request is for the word that contains the target. No instruction from before the redirect is presented after the redirect cycle, and responses to requests made before it are accepted and dropped.
- R7: When target bit 1 is set, the first instruction after the redirect starts at the upper half of the first fetched word. The lower half of that word is never presented.
- R8: While `ins_valid` is high and `ins_ready` is low, and no redirect arrives, `ins_valid`, `ins_data`, `ins_pc` and `ins_is32` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| redir_valid | input | 1 | Redirect strobe for a taken branch or jump |
| redir_pc | input | PC_W | Redirect target byte address (bit 0 ignored) |
| mem_req_valid | output | 1 | Word fetch request offered |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | PC_W | Word-aligned fetch byte address |
| mem_rsp_valid | input | 1 | Fetched word available |
| mem_rsp_ready | output | 1 | Aligner takes the fetched word |
| mem_rsp_data | input | 32 | Fetched word, lower address in bits 15:0 |
| ins_valid | output | 1 | Instruction presented |
| ins_ready | input | 1 | Decode takes the instruction |
| ins_data | output | 32 | Instruction, 16-bit forms zero-extended |
| ins_pc | output | PC_W | Byte address of the instruction |
| ins_is32 | output | 1 | 1 for a 32-bit instruction, 0 for 16-bit |

## Verification
The bench builds the block with PC_W = 12 and RESET_PC = 12'h002. The odd reset start makes the very first fetch drop its lower half. The 4 KiB address space is small enough that the PC and the fetch address wrap within the run. Memory contents come from a computed function in three mixes: all 16-bit, all 32-bit starting at an odd halfword (so every instruction straddles a word), and a random blend. These run under varied memory latency, random readiness on both sides, and redirects whose targets are offsets of -1024 and +1022 bytes from the current PC as well as short hops, some of them arriving while a fetch is outstanding.

// File: rtl/fa_pkg.sv
package fa_pkg;
  localparam int HALF_W = 16;
  localparam int WORD_W = 2 * HALF_W;

  typedef logic [HALF_W-1:0] half_t;
  typedef logic [WORD_W-1:0] word_t;

  // top bit of a leading halfword set -> compact instruction
  function automatic logic is_short(input half_t h);
    return h[HALF_W-1];
  endfunction
endpackage

// File: rtl/fa_req_ctrl.sv
module fa_req_ctrl #(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redir_valid,
  input  logic [PC_W-1:0] redir_pc,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PC_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic            take,
  output logic            word_in
);
  localparam logic [PC_W-1:0] WORD_STEP = PC_W'(4);

  logic [PC_W-1:0] fetch_pc;
  logic            pend;
  logic            drop;
  logic            req_fire;
  logic            rsp_fire;

  assign mem_req_valid = !pend && !redir_valid;
  assign mem_req_addr  = fetch_pc;
  assign mem_rsp_ready = pend && (drop || redir_valid || take);
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign rsp_fire      = mem_rsp_valid && mem_rsp_ready;
  assign word_in       = rsp_fire && !drop && !redir_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc <= {RESET_PC[PC_W-1:2], 2'b00};
      pend     <= 1'b0;
      drop     <= 1'b0;
    end else if (redir_valid) begin
      fetch_pc <= {redir_pc[PC_W-1:2], 2'b00};
      if (pend && !rsp_fire) begin
        drop <= 1'b1;
      end else begin
        pend <= 1'b0;
        drop <= 1'b0;
      end
    end else begin
      if (req_fire) begin
        pend     <= 1'b1;
        fetch_pc <= fetch_pc + WORD_STEP;
      end
      if (rsp_fire) begin
        pend <= 1'b0;
        drop <= 1'b0;
      end
    end
  end

  p_single_outstanding_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

  p_req_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
endmodule

// File: rtl/fa_align.sv
module fa_align
  import fa_pkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redir_valid,
  input  logic [PC_W-1:0] redir_pc,
  input  logic            word_in,
  input  word_t           word_data,
  input  logic            out_free,
  output logic            take,
  output logic            ld_valid,
  output word_t           ld_data,
  output logic [PC_W-1:0] ld_pc,
  output logic            ld_is32
);
  localparam logic [PC_W-1:0] STEP16 = PC_W'(2);
  localparam logic [PC_W-1:0] STEP32 = PC_W'(4);

  logic            hold_v, hold_v_n;
  half_t           hold_h, hold_h_n;
  logic            skip, skip_n;
  logic [PC_W-1:0] cur_pc;
  half_t           lo, hi;
  logic            hold_short;

  assign lo         = word_data[HALF_W-1:0];
  assign hi         = word_data[WORD_W-1:HALF_W];
  assign hold_short = hold_v && is_short(hold_h);
  assign take       = !redir_valid && (skip || (!hold_short && out_free));
  assign ld_pc      = cur_pc;

  always_comb begin
    ld_valid = 1'b0;
    ld_data  = '0;
    ld_is32  = 1'b0;
    hold_v_n = hold_v;
    hold_h_n = hold_h;
    skip_n   = skip;
    if (hold_short) begin
      if (out_free) begin
        ld_valid = 1'b1;
        ld_data  = {{HALF_W{1'b0}}, hold_h};
        hold_v_n = 1'b0;
      end
    end else if (word_in) begin
      if (skip) begin
        hold_v_n = 1'b1;
        hold_h_n = hi;
        skip_n   = 1'b0;
      end else if (hold_v) begin
        ld_valid = 1'b1;
        ld_is32  = 1'b1;
        ld_data  = {hold_h, lo};
        hold_h_n = hi;
      end else if (is_short(lo)) begin
        ld_valid = 1'b1;
        ld_data  = {{HALF_W{1'b0}}, lo};
        hold_v_n = 1'b1;
        hold_h_n = hi;
      end else begin
        ld_valid = 1'b1;
        ld_is32  = 1'b1;
        ld_data  = {lo, hi};
        hold_v_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_h <= '0;
      skip   <= RESET_PC[1];
      cur_pc <= {RESET_PC[PC_W-1:1], 1'b0};
    end else if (redir_valid) begin
      hold_v <= 1'b0;
      skip   <= redir_pc[1];
      cur_pc <= {redir_pc[PC_W-1:1], 1'b0};
    end else begin
      hold_v <= hold_v_n;
      hold_h <= hold_h_n;
      skip   <= skip_n;
      if (ld_valid) cur_pc <= cur_pc + (ld_is32 ? STEP32 : STEP16);
    end
  end
endmodule

// File: rtl/fa_out_reg.sv
module fa_out_reg
  import fa_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redir_valid,
  input  logic            ld_valid,
  input  word_t           ld_data,
  input  logic [PC_W-1:0] ld_pc,
  input  logic            ld_is32,
  output logic            out_free,
  output logic            ins_valid,
  input  logic            ins_ready,
  output word_t           ins_data,
  output logic [PC_W-1:0] ins_pc,
  output logic            ins_is32
);
  assign out_free = !ins_valid || ins_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_valid <= 1'b0;
      ins_data  <= '0;
      ins_pc    <= '0;
      ins_is32  <= 1'b0;
    end else if (redir_valid) begin
      ins_valid <= 1'b0;
    end else if (out_free) begin
      ins_valid <= ld_valid;
      if (ld_valid) begin
        ins_data <= ld_data;
        ins_pc   <= ld_pc;
        ins_is32 <= ld_is32;
      end
    end
  end

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready && !redir_valid) |=>
      (ins_valid && $stable(ins_data) && $stable(ins_pc) && $stable(ins_is32)));

  p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> !ins_valid);

  p_len_short_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_is32) |-> (ins_data[15] && ins_data[31:16] == 16'h0));

  p_len_long_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_is32) |-> !ins_data[31]);
endmodule

// File: rtl/fetch_aligner.sv
module fetch_aligner #(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            redir_valid,
  input  logic [PC_W-1:0] redir_pc,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PC_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  output logic            mem_rsp_ready,
  input  logic [31:0]     mem_rsp_data,
  output logic            ins_valid,
  input  logic            ins_ready,
  output logic [31:0]     ins_data,
  output logic [PC_W-1:0] ins_pc,
  output logic            ins_is32
);
  logic            take, word_in, out_free;
  logic            ld_valid, ld_is32;
  logic [31:0]     ld_data;
  logic [PC_W-1:0] ld_pc;

  fa_req_ctrl #(.PC_W(PC_W), .RESET_PC(RESET_PC)) req_i (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .take(take), .word_in(word_in)
  );

  fa_align #(.PC_W(PC_W), .RESET_PC(RESET_PC)) align_i (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .word_in(word_in), .word_data(mem_rsp_data), .out_free(out_free),
    .take(take), .ld_valid(ld_valid), .ld_data(ld_data), .ld_pc(ld_pc),
    .ld_is32(ld_is32)
  );

  fa_out_reg #(.PC_W(PC_W)) out_i (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid),
    .ld_valid(ld_valid), .ld_data(ld_data), .ld_pc(ld_pc), .ld_is32(ld_is32),
    .out_free(out_free), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_data(ins_data), .ins_pc(ins_pc), .ins_is32(ins_is32)
  );
endmodule

// File: tb/fetch_aligner_tb_top.sv
`timescale 1ns/1ps
module fetch_aligner_tb_top;
  localparam int PC_W = 12;
  localparam logic [PC_W-1:0] RST_PC = 12'h002;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            redir_valid = 1'b0;
  logic [PC_W-1:0] redir_pc = '0;
  logic            mem_req_valid, mem_req_ready = 1'b0;
  logic [PC_W-1:0] mem_req_addr;
  logic            mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [31:0]     mem_rsp_data = '0;
  logic            ins_valid, ins_ready = 1'b0;
  logic [31:0]     ins_data;
  logic [PC_W-1:0] ins_pc;
  logic            ins_is32;

  always #2.5 clk = ~clk;

  fetch_aligner #(.PC_W(PC_W), .RESET_PC(RST_PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_data(ins_data),
    .ins_pc(ins_pc), .ins_is32(ins_is32)
  );

  int checks = 0;
  int errors = 0;
  int mode = 2;          // 0 all short, 1 all long, 2 blend
  int lat = 1;
  int cyc = 0;
  int seed = 7;
  int outstanding = 0;
  int n_fire = 0, n_straddle = 0, n_odd_first = 0;
  logic [31:0] data_q[$];
  int          due_q[$];
  logic [PC_W-1:0] exp_pc = RST_PC;
  logic [PC_W-1:0] exp_fetch = {RST_PC[PC_W-1:2], 2'b00};
  bit first_after = 1'b1;
  bit stall_prev = 1'b0, redir_prev = 1'b0;
  logic [31:0] sv_data;
  logic [PC_W-1:0] sv_pc;
  logic sv_is32;

  function automatic logic [15:0] hw_at(input logic [PC_W-1:0] addr, input int m);
    int unsigned h;
    logic [15:0] v;
    logic top;
    h = int'(addr) >> 1;
    v = 16'((h * 40503 + 12345) ^ (h << 5));
    top = (m == 0) ? 1'b1 : (m == 1) ? 1'b0 : 1'(((h ^ (h >> 2) ^ (h >> 5)) & 1) != 0);
    return {top, v[14:0]};
  endfunction

  function automatic logic [31:0] word_at(input logic [PC_W-1:0] addr, input int m);
    return {hw_at(addr + PC_W'(2), m), hw_at(addr, m)};
  endfunction

  function automatic bit rnd(input int pct);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 127) % 100 < pct;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit rdy, input bit mrdy, input bit rd,
                      input logic [PC_W-1:0] tgt, input int newmode);
    logic [15:0] h0;
    logic [31:0] e_data;
    bit e_is32;
    @(negedge clk);
    if (stall_prev) begin
      chk(ins_valid == 1'b1, "R8", "valid held", 32'(ins_valid), 32'h1);
      chk(ins_data == sv_data && ins_pc == sv_pc && ins_is32 == sv_is32,
          "R8", "fields held", ins_data, sv_data);
    end
    if (redir_prev) chk(ins_valid == 1'b0, "R6", "valid after redirect", 32'(ins_valid), 32'h0);
    ins_ready = rdy;
    mem_req_ready = mrdy;
    redir_valid = rd;
    redir_pc = tgt;
    if (data_q.size() > 0 && cyc >= due_q[0]) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data = data_q[0];
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data = 32'hDEAD_BEEF;
    end
    #1;
    if (ins_valid && ins_ready) begin
      h0 = hw_at(exp_pc, mode);
      e_is32 = !h0[15];
      e_data = e_is32 ? {h0, hw_at(exp_pc + PC_W'(2), mode)} : {16'h0, h0};
      if (first_after && exp_pc[1]) begin
        n_odd_first++;
        chk(ins_pc == exp_pc, "R7", "pc at odd target", 32'(ins_pc), 32'(exp_pc));
      end else if (first_after)
        chk(ins_pc == exp_pc, "R6", "pc at target", 32'(ins_pc), 32'(exp_pc));
      else
        chk(ins_pc == exp_pc, "R3", "sequential pc", 32'(ins_pc), 32'(exp_pc));
      chk(ins_is32 == e_is32, "R1", "length flag", 32'(ins_is32), 32'(e_is32));
      if (e_is32 && exp_pc[1]) begin
        n_straddle++;
        chk(ins_data == e_data, "R2", "straddling data", ins_data, e_data);
      end else
        chk(ins_data == e_data, "R1", "instruction data", ins_data, e_data);
      exp_pc = exp_pc + (e_is32 ? PC_W'(4) : PC_W'(2));
      first_after = 1'b0;
      n_fire++;
    end
    if (mem_rsp_valid && mem_rsp_ready) begin
      void'(data_q.pop_front());
      void'(due_q.pop_front());
      outstanding--;
    end
    if (mem_req_valid && mem_req_ready) begin
      chk(outstanding == 0, "R5", "outstanding at request", 32'(outstanding), 32'h0);
      chk(mem_req_addr == exp_fetch, "R5", "request address", 32'(mem_req_addr), 32'(exp_fetch));
      data_q.push_back(word_at(mem_req_addr, mode));
      due_q.push_back(cyc + lat);
      outstanding++;
      exp_fetch = exp_fetch + PC_W'(4);
    end
    if (rd) begin
      exp_pc = {tgt[PC_W-1:1], 1'b0};
      exp_fetch = {tgt[PC_W-1:2], 2'b00};
      mode = newmode;
      first_after = 1'b1;
    end
    stall_prev = ins_valid && !ins_ready && !rd;
    sv_data = ins_data;
    sv_pc = ins_pc;
    sv_is32 = ins_is32;
    redir_prev = rd;
    cyc++;
  endtask

  task automatic run(input int n, input int rpct, input int mpct);
    for (int i = 0; i < n; i++) step(rnd(rpct), rnd(mpct), 1'b0, '0, mode);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R4: state held during reset
    chk(ins_valid == 1'b0, "R4", "valid in reset", 32'(ins_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ins_valid == 1'b0, "R4", "valid after reset", 32'(ins_valid), 32'h0);
    chk(mem_req_valid == 1'b1 && mem_req_addr == {RST_PC[PC_W-1:2], 2'b00},
        "R4", "first request", 32'(mem_req_addr), 32'({RST_PC[PC_W-1:2], 2'b00}));
    // blend, fast memory, free decode
    mode = 2; lat = 1;
    run(400, 100, 100);
    // all long from an odd halfword: every instruction straddles
    lat = 2;
    step(1'b1, 1'b1, 1'b1, 12'h102, 1);
    run(400, 100, 100);
    // all short with back-pressure on both sides
    lat = 1;
    step(1'b1, 1'b1, 1'b1, 12'h200, 0);
    run(400, 50, 60);
    // blend, slow memory, random redirects at far and near offsets
    lat = 4;
    for (int k = 0; k < 120; k++) begin
      int off;
      case (k % 7)
        0: off = -1024;
        1: off = 1022;
        2: off = 2;
        3: off = -2;
        4: off = 6;
        5: off = 100;
        default: off = -300;
      endcase
      step(rnd(70), rnd(80), 1'b1, exp_pc + PC_W'(off), (k % 5 == 0) ? 1 : 2);
      run(3 + (k % 17), 70, 80);
    end
    // back-to-back redirects, redirect while a word is pending
    lat = 3;
    step(1'b1, 1'b1, 1'b1, 12'h3FE, 2);
    step(1'b1, 1'b1, 1'b1, 12'h7F2, 2);
    step(1'b1, 1'b1, 1'b0, '0, 2);
    step(1'b1, 1'b1, 1'b1, 12'hFFE, 1);
    run(300, 100, 100);
    chk(n_straddle > 0, "R2", "straddling seen", 32'(n_straddle), 32'h1);
    chk(n_odd_first > 0, "R7", "odd targets seen", 32'(n_odd_first), 32'h1);
    chk(n_fire > 500, "R3", "instructions delivered", 32'(n_fire), 32'd500);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule